// File: doc/BRIEF.md
# Supply Monitor Interrupt Controller

This block sits between two supply comparators (one for the digital supply, one for the analog supply) and a processor interrupt line. Each comparator input is high while its supply is above the chosen trip level. The block holds one 8-bit control and status register behind a simple processor write/read port. Software uses this register to switch the monitor on, to choose the trip level driven to the comparators, to read the filtered digital comparator state, and to read or write a sticky low-supply flag.

Both comparator inputs pass through a synchronizer and a glitch filter, so a brief dip is never taken as a supply failure. While the monitor is on, a filtered low on either input raises the flag. The flag then holds until both inputs have stayed high for a programmable number of clock cycles (250 ms of clock time in the default build). Any low sample during that wait starts the wait again. Software can set the flag at any time. A software clear only takes effect when neither filtered input is low. The interrupt line is the flag gated by an external interrupt-enable input.

Top module: `supmon_irq_ctrl`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0xDE, `trip_sel_o` is 2'b11 and `irq_o` is 0, so the monitor starts disabled.
- R2: In the register, bit 0 is the monitor enable and bits 4:3 hold the trip select. The trip select is driven on `trip_sel_o` the cycle after a write: 01 is the higher threshold, 10 the lower, and 00/11 are reserved codes that are stored as written. Bits 7, 2 and 1 always read 1 and ignore writes.
- R3: Bit 6 is read-only. It reads 1 while the filtered digital input is high and 0 while it is low, and it reads 1 while the monitor is disabled.
- R4: After the synchronizer, a comparator input counts as low only once it has been low for FILT_CYCLES consecutive samples. A shorter low never sets the flag, and a high sample is taken as good at once.
- R5: While enabled, a filtered low on either input sets the flag (bit 5). The flag becomes visible SYNC_STAGES+FILT_CYCLES+1 cycles after the raw input falls.
- R6: Once both inputs return high, the flag clears by itself after HOLD_CYCLES good cycles. The clear is visible SYNC_STAGES+1+HOLD_CYCLES cycles after the raw input rises.
- R7: A synchronized low sample on either input while the flag is set restarts the hold-off count, even when the low is too short to pass the filter. The clear then comes SYNC_STAGES+HOLD_CYCLES cycles after the input rises again.
- R8: Writing 1 to bit 5 sets the flag and starts a fresh hold-off count. Writing 0 clears the flag at once when no filtered input is low, and has no effect while one is low.
- R9: `irq_o` is high exactly when the flag is set and `irq_en_i` is high.
- R10: While bit 0 is 0, the flag stays clear, the comparator inputs are ignored, and writes of 1 to bit 5 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| dig_good_i | input | 1 | Digital supply comparator, 1 = above trip level |
| ana_good_i | input | 1 | Analog supply comparator, 1 = above trip level |
| trip_sel_o | output | 2 | Trip-level select to the comparators |
| irq_en_i | input | 1 | External interrupt enable |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with SYNC_STAGES=2, FILT_CYCLES=4 and HOLD_CYCLES=20. With these values the full filter window and the full hold-off window each last only a handful of cycles, so every latency can be checked at its exact cycle. This covers the filter edge (a low of 3 samples against one of 4), a timer restart caused by a one-cycle dip just before expiry, and the software-set flag clearing on its own after exactly 20 cycles.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

    localparam int REG_W     = 8;
    localparam int N_CH      = 2;
    localparam int CH_ANA    = 0;
    localparam int CH_DIG    = 1;
    localparam int BIT_EN    = 0;
    localparam int BIT_TRIP  = 3;
    localparam int BIT_FLAG  = 5;
    localparam int BIT_STAT  = 6;

    localparam logic [REG_W-1:0] RSVD_ONES = 8'h86;

    typedef enum logic [1:0] {
        TRIP_RSV_A = 2'b00,
        TRIP_HIGH  = 2'b01,
        TRIP_LOW   = 2'b10,
        TRIP_RSV_B = 2'b11
    } trip_e;

    typedef struct packed {
        logic  enable;
        trip_e trip;
    } ctrl_t;

    typedef enum logic [1:0] {
        HO_IDLE  = 2'b00,
        HO_ALARM = 2'b01,
        HO_COUNT = 2'b10
    } hold_state_e;

    localparam ctrl_t CTRL_RESET = '{enable: 1'b0, trip: TRIP_RSV_B};

    function automatic ctrl_t decode_ctrl(input logic [REG_W-1:0] d);
        ctrl_t c;
        c.enable = d[BIT_EN];
        c.trip   = trip_e'(d[BIT_TRIP +: 2]);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] encode_read(input ctrl_t c,
                                                     input logic flag,
                                                     input logic stat);
        logic [REG_W-1:0] v;
        v = RSVD_ONES;
        v[BIT_EN]        = c.enable;
        v[BIT_TRIP +: 2] = c.trip;
        v[BIT_FLAG]      = flag;
        v[BIT_STAT]      = stat;
        return v;
    endfunction

endpackage

// File: rtl/supmon_filter.sv
module supmon_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic raw_i,
    output logic sync_o,
    output logic good_o
);
    localparam int CNT_W = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       low_cnt_q;
    logic                   good_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= raw_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            end
        end
    endgenerate

    assign sync_o = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            low_cnt_q <= '0;
            good_q    <= 1'b1;
        end else if (sync_o) begin
            low_cnt_q <= '0;
            good_q    <= 1'b1;
        end else if (low_cnt_q == LAST) begin
            good_q    <= 1'b0;
        end else begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign good_o = good_q;

    // R4: a high synchronized sample always leaves the filter good
    p_high_is_good_r4: assert property (@(posedge clk) disable iff (rst)
        (enable && sync_o) |=> good_o);

    // R4: the filtered level only drops after a low synchronized sample
    p_drop_needs_low_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(good_o) |-> !$past(sync_o));

endmodule

// File: rtl/supmon_holdoff.sv
module supmon_holdoff
    import supmon_pkg::*;
#(
    parameter int HOLD_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic any_filt_low,
    input  logic any_sync_low,
    input  logic wr_en,
    input  logic wr_flag,
    output logic flag_o
);
    localparam int CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    hold_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        if (!enable) begin
            state_d = HO_IDLE;
        end else if (any_filt_low) begin
            state_d = HO_ALARM;
        end else if (wr_en) begin
            state_d = wr_flag ? HO_COUNT : HO_IDLE;
        end else if (state_q != HO_IDLE) begin
            if (any_sync_low) begin
                state_d = HO_COUNT;
            end else if (cnt_q == LAST) begin
                state_d = HO_IDLE;
            end else begin
                state_d = HO_COUNT;
                cnt_d   = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign flag_o = (state_q != HO_IDLE);

    // R5: a filtered low while enabled raises the flag
    p_set_on_low_r5: assert property (@(posedge clk) disable iff (rst)
        (enable && any_filt_low) |=> flag_o);

    // R8: the flag never falls while a filtered input was low
    p_no_clear_low_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_o) |-> !$past(any_filt_low));

    // R6: the hold-off count stays inside its window
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R7: a synchronized low during hold-off keeps the flag and zeroes the count
    p_dip_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (enable && flag_o && !any_filt_low && any_sync_low && !wr_en)
        |=> (flag_o && cnt_q == '0));

    // R10: a disabled monitor leaves the flag clear
    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !flag_o);

endmodule

// File: rtl/supmon_regs.sv
module supmon_regs
    import supmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             flag,
    input  logic             stat,
    output ctrl_t            ctrl_o,
    output logic [REG_W-1:0] rd_data
);
    ctrl_t ctrl_q;
    logic  unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[7], wr_data[BIT_STAT], wr_data[BIT_FLAG], wr_data[2:1]};

    always_ff @(posedge clk) begin
        if (rst)        ctrl_q <= CTRL_RESET;
        else if (wr_en) ctrl_q <= decode_ctrl(wr_data);
    end

    assign ctrl_o  = ctrl_q;
    assign rd_data = encode_read(ctrl_q, flag, stat);

    // R2: a write reaches the trip-select field on the next cycle
    p_trip_write_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl_o.trip == $past(wr_data[BIT_TRIP +: 2])));

endmodule

// File: rtl/supmon_irq_ctrl.sv
module supmon_irq_ctrl
    import supmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 16,
    parameter int HOLD_CYCLES = 12_500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       dig_good_i,
    input  logic       ana_good_i,
    output logic [1:0] trip_sel_o,
    input  logic       irq_en_i,
    output logic       irq_o
);
    ctrl_t           ctrl;
    logic            flag;
    logic [N_CH-1:0] raw_in, sync_in, good_in;

    assign raw_in[CH_ANA] = ana_good_i;
    assign raw_in[CH_DIG] = dig_good_i;

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
            supmon_filter #(
                .SYNC_STAGES (SYNC_STAGES),
                .FILT_CYCLES (FILT_CYCLES)
            ) u_filt (
                .clk    (clk),
                .rst    (rst),
                .enable (ctrl.enable),
                .raw_i  (raw_in[ch]),
                .sync_o (sync_in[ch]),
                .good_o (good_in[ch])
            );
        end
    endgenerate

    supmon_holdoff #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk          (clk),
        .rst          (rst),
        .enable       (ctrl.enable),
        .any_filt_low (~&good_in),
        .any_sync_low (~&sync_in),
        .wr_en        (wr_en),
        .wr_flag      (wr_data[BIT_FLAG]),
        .flag_o       (flag)
    );

    supmon_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .flag    (flag),
        .stat    (good_in[CH_DIG]),
        .ctrl_o  (ctrl),
        .rd_data (rd_data)
    );

    assign trip_sel_o = ctrl.trip;
    assign irq_o      = flag & irq_en_i;

endmodule

// File: tb/tb_supmon_irq_ctrl.sv
module tb_supmon_irq_ctrl;
    localparam int SYNC = 2;
    localparam int FILT = 4;
    localparam int HOLD = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       dig_good_i = 1'b1;
    logic       ana_good_i = 1'b1;
    logic [1:0] trip_sel_o;
    logic       irq_en_i = 1'b1;
    logic       irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    supmon_irq_ctrl #(.SYNC_STAGES(SYNC), .FILT_CYCLES(FILT), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .dig_good_i(dig_good_i), .ana_good_i(ana_good_i), .trip_sel_o(trip_sel_o),
        .irq_en_i(irq_en_i), .irq_o(irq_o));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        step(1);
        wr_en   = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        chk("R1 reset read", rd_data, 8'hDE);
        chk("R1 reset trip", {6'd0, trip_sel_o}, 8'h03);
        chk("R1 reset irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_register;
        reg_write(8'h08);
        chk("R2 trip 01 read", rd_data, 8'hCE);
        chk("R2 trip 01 pin", {6'd0, trip_sel_o}, 8'h01);
        reg_write(8'h00);
        chk("R2 reserved read ones", rd_data, 8'hC6);
        chk("R2 trip 00 pin", {6'd0, trip_sel_o}, 8'h00);
        reg_write(8'h11);
        chk("R2 enable trip 10 read", rd_data, 8'hD7);
        chk("R2 trip 10 pin", {6'd0, trip_sel_o}, 8'h02);
    endtask

    task automatic t_digital_low;
        dig_good_i = 1'b0;
        step(SYNC + FILT - 1);
        chk("R3 status before filter", {7'd0, rd_data[6]}, 8'h01);
        step(1);
        chk("R3 status low", {7'd0, rd_data[6]}, 8'h00);
        chk("R5 flag not yet", {7'd0, rd_data[5]}, 8'h00);
        step(1);
        chk("R5 flag set digital", {7'd0, rd_data[5]}, 8'h01);
        reg_write(8'h51);
        chk("R3 status write ignored", {7'd0, rd_data[6]}, 8'h00);
        chk("R8 clear ignored while low", {7'd0, rd_data[5]}, 8'h01);
        dig_good_i = 1'b1;
        step(SYNC);
        chk("R3 status still low", {7'd0, rd_data[6]}, 8'h00);
        step(1);
        chk("R3 status back high", {7'd0, rd_data[6]}, 8'h01);
        step(HOLD - 1);
        chk("R6 flag held", {7'd0, rd_data[5]}, 8'h01);
        step(1);
        chk("R6 flag auto clear", {7'd0, rd_data[5]}, 8'h00);
    endtask

    task automatic t_analog_low;
        ana_good_i = 1'b0;
        step(SYNC + FILT);
        chk("R5 analog flag not yet", {7'd0, rd_data[5]}, 8'h00);
        step(1);
        chk("R5 flag set analog", {7'd0, rd_data[5]}, 8'h01);
        chk("R3 status ignores analog", {7'd0, rd_data[6]}, 8'h01);
        ana_good_i = 1'b1;
        step(SYNC + HOLD);
        chk("R6 analog flag held", {7'd0, rd_data[5]}, 8'h01);
        step(1);
        chk("R6 analog auto clear", {7'd0, rd_data[5]}, 8'h00);
    endtask

    task automatic t_glitch;
        dig_good_i = 1'b0;
        repeat (FILT - 1) @(posedge clk);
        @(negedge clk);
        dig_good_i = 1'b1;
        step(SYNC + FILT + 4);
        chk("R4 short low filtered", {7'd0, rd_data[5]}, 8'h00);
        chk("R4 short low status", {7'd0, rd_data[6]}, 8'h01);
        dig_good_i = 1'b0;
        repeat (FILT) @(posedge clk);
        @(negedge clk);
        dig_good_i = 1'b1;
        step(SYNC + 2);
        chk("R4 full-length low trips", {7'd0, rd_data[5]}, 8'h01);
        step(HOLD + 2);
        chk("R6 clear after trip", {7'd0, rd_data[5]}, 8'h00);
    endtask

    task automatic t_dip_restart;
        dig_good_i = 1'b0;
        step(SYNC + FILT + 1);
        chk("R5 flag set for restart", {7'd0, rd_data[5]}, 8'h01);
        dig_good_i = 1'b1;
        step(SYNC + 1 + HOLD - 5);
        ana_good_i = 1'b0;
        step(1);
        ana_good_i = 1'b1;
        step(SYNC + HOLD - 1);
        chk("R7 restart keeps flag", {7'd0, rd_data[5]}, 8'h01);
        step(1);
        chk("R7 clear after restart", {7'd0, rd_data[5]}, 8'h00);
    endtask

    task automatic t_sw_write;
        reg_write(8'h31);
        chk("R8 software set", rd_data, 8'hF7);
        reg_write(8'h11);
        chk("R8 software clear", rd_data, 8'hD7);
        reg_write(8'h31);
        step(HOLD - 1);
        chk("R8 set flag held", {7'd0, rd_data[5]}, 8'h01);
        step(1);
        chk("R8 set flag expires", {7'd0, rd_data[5]}, 8'h00);
    endtask

    task automatic t_irq_gate;
        chk("R9 irq low with flag clear", {7'd0, irq_o}, 8'h00);
        reg_write(8'h31);
        irq_en_i = 1'b0;
        step(0);
        chk("R9 irq masked", {7'd0, irq_o}, 8'h00);
        irq_en_i = 1'b1;
        step(0);
        chk("R9 irq asserted", {7'd0, irq_o}, 8'h01);
        reg_write(8'h11);
        chk("R9 irq drops on clear", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_disabled;
        reg_write(8'h10);
        dig_good_i = 1'b0;
        ana_good_i = 1'b0;
        step(SYNC + FILT + 4);
        chk("R10 inputs ignored", rd_data, 8'hD6);
        chk("R10 irq low", {7'd0, irq_o}, 8'h00);
        reg_write(8'h30);
        chk("R10 set discarded", rd_data, 8'hD6);
        dig_good_i = 1'b1;
        ana_good_i = 1'b1;
        step(SYNC + 1);
        reg_write(8'h11);
        step(2);
        chk("R10 re-enable clean", rd_data, 8'hD7);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_register;
        t_digital_low;
        t_analog_low;
        t_glitch;
        t_dip_restart;
        t_sw_write;
        t_irq_gate;
        t_disabled;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule